// File: doc/BRIEF.md
# Total-Store-Order Store Buffer with Load Forwarding

This block sits between one processor core and a shared memory port and gives total-store-order behaviour. Stores from the core are queued and leave for memory strictly oldest first. A load first searches the queue. When one or more queued stores target the same word, the load returns the data of the youngest of them. Otherwise it reads memory, and it may do so ahead of older queued stores to other addresses. The oldest queued store is written to memory on every cycle in which the memory port is free and no other core owns the global lock.

The core issues one request at a time through a valid/ready handshake. Each request is a load, a store, one of three fence kinds, or a locked swap. A full-barrier fence holds the core until the queue is empty. Load-only and store-only fences are acknowledged at once, because loads are already served in program order and stores already leave in issue order. A locked swap raises a lock request and waits for the grant. It then empties the queue, reads the old word, writes the new word, returns the old value and drops the lock request. A plain store that releases a critical section needs no flush, since the queue order already places it behind every earlier store. An input tells the block when another core holds the lock. While that input is high the block neither writes nor reads memory.

Top module: `tso_store_buffer`

## Requirements
- R1: Queued stores are written to memory in the order they were accepted, so after the queue drains each address holds the value of its last accepted store.
- R2: A load (req_op = 0) whose word address matches queued stores returns the data of the most recently accepted matching store, with resp_valid one cycle after acceptance, even while lock_other is high.
- R3: A load with no matching queued store returns the memory word at its address, read through mem_rd_en with the data taken from mem_rdata one cycle later.
- R4: A store (req_op = 1) is held off with req_ready low while the queue holds DEPTH entries; a load is still accepted in that state.
- R5: A full fence (req_op = 4) is acknowledged on resp_valid only after every queued store has been written to memory, and no request is accepted before that acknowledgement.
- R6: A load-only fence (req_op = 2) and a store-only fence (req_op = 3) are acknowledged one cycle after acceptance without waiting for the queue to drain.
- R7: While lock_other is high, mem_wr_en and mem_rd_en stay low, so a load that misses in the queue waits.
- R8: When the queue is not empty, lock_other is low and no read uses the port, the oldest entry is written to memory in that cycle.
- R9: A locked swap (req_op = 5) raises lock_req, waits for lock_gnt, drains the queue, then reads the old word and writes req_wdata. It returns the old word on resp_valid with lock_req already low.
- R10: A synchronous active-high reset empties the queue without writing its entries, drops lock_req and resp_valid, and leaves req_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_op | input | 3 | Request kind: 0 load, 1 store, 2 load fence, 3 store fence, 4 full fence, 5 locked swap |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store or swap data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| resp_valid | output | 1 | One-cycle pulse: load data, fence acknowledge or swap old value |
| resp_rdata | output | DW | Response data |
| lock_req | output | 1 | Global lock request, held through a locked swap |
| lock_gnt | input | 1 | Global lock granted to this core |
| lock_other | input | 1 | Another core holds the global lock |
| mem_rd_en | output | 1 | Memory read strobe, data expected on mem_rdata one cycle later |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
A wrong queue pointer or fill count shows up as a stale or out-of-order value on a forwarded load in the very next cycle. It also shows up as a wrong final memory image once the queue has drained, within DEPTH cycles. A control state stuck in a fence or lock phase shows at the ports as req_ready held low and a missing response. Writes leaking while lock_other is high appear on mem_wr_en in the same cycle. The sweeps store short runs with repeated addresses and then load every address in a small space, compare each result against a running last-written image, and afterwards compare the whole memory.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_LFENCE = 3'd2,
    OP_SFENCE = 3'd3,
    OP_MFENCE = 3'd4,
    OP_SWAP   = 3'd5
  } tsb_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LD_ISSUE,
    S_LD_WAIT,
    S_FENCE,
    S_LK_ACQ,
    S_LK_DRAIN,
    S_LK_RD,
    S_LK_WR
  } tsb_state_e;

endpackage

// File: rtl/tsb_fifo.sv
module tsb_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [DEPTH-1:0][AW-1:0] ent_addr,
  output logic [DEPTH-1:0][DW-1:0] ent_data,
  output logic [PW-1:0]            head_ptr,
  output logic [CW-1:0]            fill,
  output logic                     full,
  output logic                     empty,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data
);

  logic [PW-1:0] tail_ptr;

  // storage carries no reset: only the pointers define which slots are live
  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_ptr] <= push_addr;
      ent_data[tail_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_ptr <= '0;
      head_ptr <= '0;
      fill     <= '0;
    end else begin
      if (push) tail_ptr <= tail_ptr + 1'b1;
      if (pop)  head_ptr <= head_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign full      = (fill == CW'(DEPTH));
  assign empty     = (fill == '0);
  assign head_addr = ent_addr[head_ptr];
  assign head_data = ent_data[head_ptr];

endmodule

// File: rtl/tsb_fwd.sv
module tsb_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [PW-1:0]            head_ptr,
  input  logic [CW-1:0]            fill,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);

  // walk from oldest to youngest live slot; a later match overrides an
  // earlier one, so the youngest matching store wins
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CW'(k) < fill) &&
          (ent_addr[head_ptr + PW'(k)] == look_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[head_ptr + PW'(k)];
      end
    end
  end

endmodule

// File: rtl/tsb_ctrl.sv
module tsb_ctrl
  import tsb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  input  logic          q_full,
  input  logic          q_empty,
  input  logic          fwd_hit,
  input  logic [DW-1:0] fwd_data,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          push,
  output logic          pop,
  output logic          lock_req,
  input  logic          lock_gnt,
  input  logic          lock_other,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  tsb_state_e    state;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          fire, rd_ld, rd_lk, wr_lk, drain;

  assign req_ready = (state == S_IDLE) && !((req_op == OP_STORE) && q_full);
  assign fire      = req_valid && req_ready;
  assign push      = fire && (req_op == OP_STORE);

  // memory port: a read outranks draining; nothing moves while the lock is elsewhere
  assign rd_ld     = (state == S_LD_ISSUE) && !lock_other;
  assign rd_lk     = (state == S_LK_RD);
  assign wr_lk     = (state == S_LK_WR);
  assign mem_rd_en = rd_ld || rd_lk;
  assign drain     = !q_empty && !lock_other && !mem_rd_en && !wr_lk;
  assign pop       = drain;
  assign mem_wr_en = drain || wr_lk;
  assign mem_addr  = (mem_rd_en || wr_lk) ? op_addr : head_addr;
  assign mem_wdata = wr_lk ? op_wdata : head_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      lock_req   <= 1'b0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      op_addr    <= '0;
      op_wdata   <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (fire) begin
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            case (req_op)
              OP_LOAD: begin
                if (fwd_hit) begin
                  resp_valid <= 1'b1;
                  resp_rdata <= fwd_data;
                end else begin
                  state <= S_LD_ISSUE;
                end
              end
              OP_STORE:  ;
              OP_MFENCE: state <= S_FENCE;
              OP_SWAP: begin
                lock_req <= 1'b1;
                state    <= S_LK_ACQ;
              end
              default:   resp_valid <= 1'b1;
            endcase
          end
        end
        S_LD_ISSUE: if (!lock_other) state <= S_LD_WAIT;
        S_LD_WAIT: begin
          resp_valid <= 1'b1;
          resp_rdata <= mem_rdata;
          state      <= S_IDLE;
        end
        S_FENCE: begin
          if (q_empty) begin
            resp_valid <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_LK_ACQ:   if (lock_gnt) state <= S_LK_DRAIN;
        S_LK_DRAIN: if (q_empty)  state <= S_LK_RD;
        S_LK_RD:    state <= S_LK_WR;
        S_LK_WR: begin
          resp_valid <= 1'b1;
          resp_rdata <= mem_rdata;
          lock_req   <= 1'b0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          lock_req,
  input  logic          lock_gnt,
  input  logic          lock_other,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [PW-1:0]            head_ptr;
  logic [CW-1:0]            fill;
  logic                     q_full, q_empty, push, pop, fwd_hit;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data, fwd_data;

  tsb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (pop),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .head_ptr  (head_ptr),
    .fill      (fill),
    .full      (q_full),
    .empty     (q_empty),
    .head_addr (head_addr),
    .head_data (head_data)
  );

  tsb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .head_ptr  (head_ptr),
    .fill      (fill),
    .look_addr (req_addr),
    .hit       (fwd_hit),
    .hit_data  (fwd_data)
  );

  tsb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .q_full     (q_full),
    .q_empty    (q_empty),
    .fwd_hit    (fwd_hit),
    .fwd_data   (fwd_data),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .push       (push),
    .pop        (pop),
    .lock_req   (lock_req),
    .lock_gnt   (lock_gnt),
    .lock_other (lock_other),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
  );

endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic          req_ready,
  input logic          resp_valid,
  input logic          lock_req,
  input logic          lock_gnt,
  input logic          lock_other,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [CW-1:0] fill
);

  p_port_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    lock_other |-> (!mem_wr_en && !mem_rd_en));

  p_drain_free_r8: assert property (@(posedge clk) disable iff (rst)
    ((fill != '0) && !lock_other && !mem_rd_en) |-> mem_wr_en);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  p_full_stall_r4: assert property (@(posedge clk) disable iff (rst)
    ((fill == CW'(DEPTH)) && (req_op == 3'd1)) |-> !req_ready);

  p_store_grows_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_op == 3'd1) && !mem_wr_en) |=> (fill == $past(fill) + 1'b1));

  p_swap_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && (fill == '0)) |-> (lock_req && lock_gnt));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> ((fill == '0) && !lock_req && !resp_valid));

endmodule

bind tso_store_buffer tsb_checker #(.DEPTH(DEPTH)) u_tsb_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .lock_req   (lock_req),
  .lock_gnt   (lock_gnt),
  .lock_other (lock_other),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .fill       (fill)
);

// File: tb/test_tso_store_buffer.sv
module test_tso_store_buffer;

  localparam int DEPTH = 4;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int MSZ   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, resp_valid, lock_req, mem_rd_en, mem_wr_en;
  logic [DW-1:0] resp_rdata, mem_wdata, mem_rdata;
  logic          lock_gnt, lock_other;
  logic [AW-1:0] mem_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int wcount  = 0;
  int bad_port = 0;
  logic [DW-1:0] mem [MSZ];
  logic [DW-1:0] shadow [MSZ];
  int wlog_addr [256];
  int wlog_data [256];
  int wlog_cyc  [256];

  always #10 clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_tso_store_buffer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .lock_req(lock_req),
    .lock_gnt(lock_gnt), .lock_other(lock_other), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // memory model: one-cycle read latency, writes logged in arrival order
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < MSZ; i++) mem[i] <= DW'(i * 7 + 1);
      mem_rdata <= '0;
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
      if (mem_wr_en) begin
        mem[mem_addr] <= mem_wdata;
        wlog_addr[wcount % 256] <= int'(mem_addr);
        wlog_data[wcount % 256] <= int'(mem_wdata);
        wlog_cyc[wcount % 256]  <= cyc;
        wcount <= wcount + 1;
      end
      if (lock_other && (mem_wr_en || mem_rd_en)) bad_port <= bad_port + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input int a, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_wdata = DW'(d);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic get_resp(input int window, output int data, output bit ok);
    ok = 1'b0; data = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (resp_valid) begin
        ok = 1'b1; data = int'(resp_rdata);
        return;
      end
    end
  endtask

  task automatic store(input int a, input int d);
    send(3'd1, a, d);
    shadow[a] = DW'(d);
  endtask

  task automatic load(input int a, output int data, output bit ok);
    send(3'd0, a, 0);
    get_resp(40, data, ok);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < MSZ; i++) shadow[i] = DW'(i * 7 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int  d, w0;
    bit  ok;
    bit  inbuf [8];
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    lock_gnt = 1'b0; lock_other = 1'b0;
    do_reset();
    @(negedge clk);
    // R10: reset state
    check("R10 ready after reset", int'(req_ready), 1);
    check("R10 lock_req after reset", int'(lock_req), 0);
    check("R10 resp_valid after reset", int'(resp_valid), 0);

    // R2/R4/R7: fill under a foreign lock, forward youngest, stall when full
    lock_other = 1'b1;
    store(3, 8'h11); store(5, 8'h22); store(3, 8'h33); store(7, 8'h44);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = 4'd9; req_wdata = 8'h55; #1;
    check("R4 store stalled when full", int'(req_ready), 0);
    req_op = 3'd0; #1;
    check("R4 load accepted when full", int'(req_ready), 1);
    req_valid = 1'b0;
    load(3, d, ok); check("R2 youngest of two matches", d, 8'h33);
    load(5, d, ok); check("R2 single match", d, 8'h22);
    load(7, d, ok); check("R2 newest entry", d, 8'h44);
    check("R7 no drain under foreign lock", wcount, 0);
    send(3'd0, 9, 0);
    get_resp(10, d, ok);
    check("R7 missing load waits for lock", int'(ok), 0);
    @(negedge clk); lock_other = 1'b0;
    get_resp(40, d, ok);
    check("R3 miss reads memory", d, 9 * 7 + 1);
    repeat (8) @(negedge clk);
    check("R1 drained entries", wcount, 4);
    check("R1 order 0", wlog_data[0], 8'h11);
    check("R1 order 1", wlog_data[1], 8'h22);
    check("R1 order 2", wlog_data[2], 8'h33);
    check("R1 order 3", wlog_data[3], 8'h44);
    check("R8 back-to-back drain", wlog_cyc[3] - wlog_cyc[1], 2);

    // R1/R2/R3 sweep: short runs with repeated addresses, every address loaded
    for (int p = 0; p < 12; p++) begin
      int n;
      @(negedge clk); lock_other = 1'b1;
      for (int a = 0; a < 8; a++) inbuf[a] = 1'b0;
      n = p % 4 + 1;
      for (int k = 0; k < n; k++) begin
        int a;
        a = (p + k * (p % 3)) % 4 + (p % 2) * 4;
        store(a, p * 16 + k + 1);
        inbuf[a] = 1'b1;
      end
      for (int a = 0; a < 8; a++)
        if (inbuf[a]) begin
          load(a, d, ok);
          check("R2 sweep forwarded", d, int'(shadow[a]));
        end
      @(negedge clk); lock_other = 1'b0;
      for (int a = 0; a < 8; a++)
        if (!inbuf[a]) begin
          load(a, d, ok);
          check("R3 sweep memory", d, int'(shadow[a]));
        end
      repeat (DEPTH + 2) @(negedge clk);
      for (int a = 0; a < 8; a++) check("R1 sweep image", int'(mem[a]), int'(shadow[a]));
    end

    // R5: full fence holds until drained
    @(negedge clk); lock_other = 1'b1;
    w0 = wcount;
    store(12, 8'h61); store(13, 8'h62);
    send(3'd4, 0, 0);
    get_resp(8, d, ok);
    check("R5 fence not acked while queued", int'(ok), 0);
    check("R5 core stalled", int'(req_ready), 0);
    lock_other = 1'b0;
    get_resp(40, d, ok);
    check("R5 fence acked", int'(ok), 1);
    check("R5 queue empty at ack", wcount - w0, 2);

    // R6: load and store fences do not wait
    @(negedge clk); lock_other = 1'b1;
    w0 = wcount;
    store(14, 8'h71);
    send(3'd2, 0, 0);
    get_resp(2, d, ok);
    check("R6 load fence immediate", int'(ok), 1);
    send(3'd3, 0, 0);
    get_resp(2, d, ok);
    check("R6 store fence immediate", int'(ok), 1);
    check("R6 entry still queued", wcount - w0, 0);
    lock_other = 1'b0;
    repeat (4) @(negedge clk);

    // R9: locked swap
    lock_other = 1'b1;
    w0 = wcount;
    store(10, 8'hA1); store(10, 8'hA2);
    send(3'd5, 10, 8'h5C);
    repeat (2) @(negedge clk);
    check("R9 lock requested", int'(lock_req), 1);
    get_resp(5, d, ok);
    check("R9 waits for grant", int'(ok), 0);
    lock_other = 1'b0; lock_gnt = 1'b1;
    get_resp(40, d, ok);
    check("R9 old value returned", d, 8'hA2);
    check("R9 lock dropped at response", int'(lock_req), 0);
    lock_gnt = 1'b0;
    check("R9 drained then swapped", wcount - w0, 3);
    check("R9 last write is swap", wlog_data[(wcount - 1) % 256], 8'h5C);
    check("R9 memory holds new word", int'(mem[10]), 8'h5C);

    // R10: reset discards queued stores
    lock_other = 1'b1;
    store(2, 8'h91); store(4, 8'h92);
    do_reset();
    w0 = wcount;
    lock_other = 1'b0;
    repeat (8) @(negedge clk);
    check("R10 queue discarded", wcount - w0, 0);
    check("R10 ready after mid reset", int'(req_ready), 1);
    check("R7 port idle under foreign lock", bad_port, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule